// File: doc/BRIEF.md
# March and Background Memory Test Engine

This block is a built-in self-test sequencer for one single-port SRAM arranged as a grid of rows and columns. A single start pulse, sampled together with a 6-bit pattern code and a 4-bit data seed, launches one algorithm. The engine then drives the memory address, read strobe, write strobe and write data, one access per cycle, until the algorithm ends. Each read is checked against the data background that the algorithm expects at that address. The engine reports the outcome with a sticky fail flag and records the address and expected word of the first mismatch.

There are two families of algorithm. The background scans fill the array with a data pattern and read it back. The pattern is solid, row striped, column striped or checkerboard, and the scan then repeats with the pattern inverted. The marches apply short read/write elements at each address in ascending and descending order: an RW march, an RWR march and March C. Either family can step the column or the row as the fast-moving axis, so faults along both the word lines and the bit lines are exercised.

Top module: `mbist_engine`

## Requirements
- R1: After reset `busy`, `done`, `fail`, `mem_we` and `mem_re` are all 0, and no access is made until a start is accepted.
- R2: `pattern_sel[2:0]` picks the algorithm. The codes are 0 checkerboard, 1 column stripe, 2 row stripe, 3 solid, 4 RW march, 5 RWR march and 6 March C. `pattern_sel[3]`=1 selects column-fast order. A code with `pattern_sel[5:4]` not zero, or with algorithm 7, makes no access: `done` is 1 in the cycle after the start, and `fail` is 0.
- R3: `mem_addr` = row*COLS + col, with the row in the upper bits. Row-fast order steps the column first within each row. Column-fast order steps the row first within each column. Ascending order runs the linear position 0 to max, and descending order runs it from max to 0.
- R4: The data word is the seed repeated in every nibble. Scans XOR it with all ones when the row LSB XOR the column LSB is 1 (checkerboard), when the column LSB is 1 (column stripe) or when the row LSB is 1 (row stripe); solid scans never do so. Marches use the plain seed word D.
- R5: A scan runs four ascending passes: write the background, read the background, write its inverse, read its inverse.
- R6: The RW march runs: write D ascending; read D then write ~D at each address ascending; read ~D then write D at each address descending; read D ascending.
- R7: The RWR march is the RW march with the elements R D, W ~D, R ~D ascending and R ~D, W D, R D descending.
- R8: March C runs: W D ascending; (R D, W ~D, R ~D) ascending; (R ~D, W D, R D) ascending; (R D, W ~D, R ~D) descending; (R ~D, W D, R D) descending; R D descending.
- R9: The first access comes in the cycle after the start. The engine makes exactly one access per cycle with no gaps, never reads and writes in the same cycle, and holds `busy` at 1 during the run.
- R10: Read data is compared one cycle after the read is issued. On the first mismatch `fail` rises and stays at 1, and `fail_addr`/`fail_expected` keep the first failing address and its expected word until the next start.
- R11: `done` rises two cycles after the last access and stays at 1 until the next start. A start taken while idle or done clears `fail`, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken when idle or done |
| pattern_sel | input | 6 | Algorithm code and fast-axis select |
| seed | input | 4 | Data seed, repeated across the word |
| mem_addr | output | ROW_BITS+COL_BITS | Memory address {row, col} |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data expected on the next cycle |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after mem_re |
| busy | output | 1 | Algorithm running |
| done | output | 1 | Algorithm finished |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ROW_BITS+COL_BITS | Address of the first mismatch |
| fail_expected | output | DATA_W | Expected word at the first mismatch |

## Verification
The access outputs are combinational from the engine state. The bench therefore compares each expected access in the cycle it is due: the first access one cycle after start, then one per cycle. The bench samples every access at the falling edge. A read issued in cycle t is compared at the edge that ends t+1, so `fail` and its captured fields are first visible in t+2. `done` appears two cycles after the last access, and the bench samples it there and again several cycles later. Expected addresses, data, first failure and end of run all come from a reference walk of the algorithm in the bench over a 4x4 array, run against a memory model with an optional stuck-at-1 bit.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        ALG_CKBD   = 3'd0,
        ALG_COLS   = 3'd1,
        ALG_ROWS   = 3'd2,
        ALG_SOLID  = 3'd3,
        ALG_RW     = 3'd4,
        ALG_RWR    = 3'd5,
        ALG_MARCHC = 3'd6,
        ALG_NONE   = 3'd7
    } alg_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_DRAIN = 2'd2,
        S_DONE  = 2'd3
    } state_e;

    // One memory operation inside a march element.
    typedef struct packed {
        logic rd;
        logic wr;
        logic inv;   // use the inverted background
    } op_t;

    // One march element: up to three operations per address.
    typedef struct packed {
        logic [1:0] last_op;
        logic       down;
        op_t        op2;
        op_t        op1;
        op_t        op0;
    } elem_t;

    localparam op_t OP_NONE = '{rd: 1'b0, wr: 1'b0, inv: 1'b0};
    localparam op_t OP_R    = '{rd: 1'b1, wr: 1'b0, inv: 1'b0};
    localparam op_t OP_RB   = '{rd: 1'b1, wr: 1'b0, inv: 1'b1};
    localparam op_t OP_W    = '{rd: 1'b0, wr: 1'b1, inv: 1'b0};
    localparam op_t OP_WB   = '{rd: 1'b0, wr: 1'b1, inv: 1'b1};

    function automatic elem_t mk_elem(input logic down, input logic [1:0] last,
                                      input op_t a, input op_t b, input op_t c);
        elem_t e;
        e.last_op = last;
        e.down    = down;
        e.op0     = a;
        e.op1     = b;
        e.op2     = c;
        return e;
    endfunction

    function automatic op_t pick_op(input elem_t e, input logic [1:0] i);
        case (i)
            2'd0:    return e.op0;
            2'd1:    return e.op1;
            default: return e.op2;
        endcase
    endfunction

    function automatic logic is_scan(input alg_e a);
        return (a == ALG_CKBD) || (a == ALG_COLS) || (a == ALG_ROWS) || (a == ALG_SOLID);
    endfunction

    function automatic elem_t elem_of(input alg_e a, input logic [2:0] e);
        if (is_scan(a)) begin
            case (e)
                3'd0:    return mk_elem(1'b0, 2'd0, OP_W,  OP_NONE, OP_NONE);
                3'd1:    return mk_elem(1'b0, 2'd0, OP_R,  OP_NONE, OP_NONE);
                3'd2:    return mk_elem(1'b0, 2'd0, OP_WB, OP_NONE, OP_NONE);
                default: return mk_elem(1'b0, 2'd0, OP_RB, OP_NONE, OP_NONE);
            endcase
        end else if (a == ALG_RW) begin
            case (e)
                3'd0:    return mk_elem(1'b0, 2'd0, OP_W,  OP_NONE, OP_NONE);
                3'd1:    return mk_elem(1'b0, 2'd1, OP_R,  OP_WB,   OP_NONE);
                3'd2:    return mk_elem(1'b1, 2'd1, OP_RB, OP_W,    OP_NONE);
                default: return mk_elem(1'b0, 2'd0, OP_R,  OP_NONE, OP_NONE);
            endcase
        end else if (a == ALG_RWR) begin
            case (e)
                3'd0:    return mk_elem(1'b0, 2'd0, OP_W,  OP_NONE, OP_NONE);
                3'd1:    return mk_elem(1'b0, 2'd2, OP_R,  OP_WB,   OP_RB);
                3'd2:    return mk_elem(1'b1, 2'd2, OP_RB, OP_W,    OP_R);
                default: return mk_elem(1'b0, 2'd0, OP_R,  OP_NONE, OP_NONE);
            endcase
        end else begin
            case (e)
                3'd0:    return mk_elem(1'b0, 2'd0, OP_W,  OP_NONE, OP_NONE);
                3'd1:    return mk_elem(1'b0, 2'd2, OP_R,  OP_WB,   OP_RB);
                3'd2:    return mk_elem(1'b0, 2'd2, OP_RB, OP_W,    OP_R);
                3'd3:    return mk_elem(1'b1, 2'd2, OP_R,  OP_WB,   OP_RB);
                3'd4:    return mk_elem(1'b1, 2'd2, OP_RB, OP_W,    OP_R);
                default: return mk_elem(1'b1, 2'd0, OP_R,  OP_NONE, OP_NONE);
            endcase
        end
    endfunction

    function automatic logic [2:0] final_elem(input alg_e a);
        return (a == ALG_MARCHC) ? 3'd5 : 3'd3;
    endfunction

    // Address-dependent background inversion.
    function automatic logic bg_flip(input alg_e a, input logic r0, input logic c0);
        case (a)
            ALG_CKBD: return r0 ^ c0;
            ALG_COLS: return c0;
            ALG_ROWS: return r0;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic code_ok(input logic [5:0] s);
        return (s[5:4] == 2'b00) && (s[2:0] != 3'd7);
    endfunction

endpackage

// File: rtl/mbist_addr.sv
module mbist_addr #(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                load_down,
    input  logic                step,
    input  logic                dir_down,
    input  logic                col_fast,
    output logic [ROW_BITS-1:0] row,
    output logic [COL_BITS-1:0] col,
    output logic                at_end
);
    localparam int ADDR_W = ROW_BITS + COL_BITS;

    logic [ADDR_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (load) begin
            pos_q <= load_down ? '1 : '0;
        end else if (step) begin
            pos_q <= dir_down ? pos_q - 1'b1 : pos_q + 1'b1;
        end
    end

    always_comb begin
        if (col_fast) begin
            row = pos_q[ROW_BITS-1:0];
            col = pos_q[ADDR_W-1:ROW_BITS];
        end else begin
            col = pos_q[COL_BITS-1:0];
            row = pos_q[ADDR_W-1:COL_BITS];
        end
        at_end = dir_down ? (pos_q == '0) : (pos_q == '1);
    end
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [5:0] sel,
    input  logic       at_end,
    output logic       launch,
    output logic       accept,
    output logic       issue,
    output op_t        op,
    output logic       load,
    output logic       load_down,
    output logic       step,
    output logic       dir_down,
    output alg_e       alg,
    output logic       col_fast,
    output logic       busy,
    output logic       done
);
    state_e     state_q;
    logic [2:0] elem_q;
    logic [1:0] opi_q;
    elem_t      cur, nxt;
    logic       last_op, elem_end, run_end;

    always_comb begin
        cur       = elem_of(alg, elem_q);
        nxt       = elem_of(alg, elem_q + 3'd1);
        issue     = (state_q == S_RUN);
        op        = issue ? pick_op(cur, opi_q) : OP_NONE;
        last_op   = (opi_q == cur.last_op);
        elem_end  = issue && last_op && at_end;
        run_end   = elem_end && (elem_q == final_elem(alg));
        launch    = start && ((state_q == S_IDLE) || (state_q == S_DONE));
        accept    = launch && code_ok(sel);
        load      = accept || (elem_end && !run_end);
        load_down = accept ? 1'b0 : nxt.down;
        step      = issue && last_op && !at_end;
        dir_down  = cur.down;
        busy      = (state_q == S_RUN) || (state_q == S_DRAIN);
        done      = (state_q == S_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            elem_q   <= '0;
            opi_q    <= '0;
            alg      <= ALG_SOLID;
            col_fast <= 1'b0;
        end else begin
            case (state_q)
                S_RUN: begin
                    if (!last_op) begin
                        opi_q <= opi_q + 2'd1;
                    end else begin
                        opi_q <= '0;
                        if (run_end) begin
                            state_q <= S_DRAIN;
                        end else if (elem_end) begin
                            elem_q <= elem_q + 3'd1;
                        end
                    end
                end
                S_DRAIN: state_q <= S_DONE;
                default: begin
                    if (accept) begin
                        state_q  <= S_RUN;
                        alg      <= alg_e'(sel[2:0]);
                        col_fast <= sel[3];
                        elem_q   <= '0;
                        opi_q    <= '0;
                    end else if (launch) begin
                        state_q <= S_DONE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              rd_issue,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_expect,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_expected
);
    logic              chk_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_q  <= 1'b0;
            addr_q <= '0;
            exp_q  <= '0;
        end else begin
            chk_q  <= rd_issue;
            addr_q <= rd_addr;
            exp_q  <= rd_expect;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail          <= 1'b0;
            fail_addr     <= '0;
            fail_expected <= '0;
        end else if (chk_q && !fail && (rdata != exp_q)) begin
            fail          <= 1'b1;
            fail_addr     <= addr_q;
            fail_expected <= exp_q;
        end
    end
endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
    import mbist_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2,
    parameter int DATA_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [5:0]                   pattern_sel,
    input  logic [3:0]                   seed,
    output logic [ROW_BITS+COL_BITS-1:0] mem_addr,
    output logic                         mem_we,
    output logic                         mem_re,
    output logic [DATA_W-1:0]            mem_wdata,
    input  logic [DATA_W-1:0]            mem_rdata,
    output logic                         busy,
    output logic                         done,
    output logic                         fail,
    output logic [ROW_BITS+COL_BITS-1:0] fail_addr,
    output logic [DATA_W-1:0]            fail_expected
);
    localparam int ADDR_W = ROW_BITS + COL_BITS;
    localparam int REP    = DATA_W / 4;

    logic                launch, accept, issue, load, load_down, step, dir_down, col_fast, at_end;
    op_t                 op;
    alg_e                alg;
    logic [ROW_BITS-1:0] row;
    logic [COL_BITS-1:0] col;
    logic [3:0]          seed_q;
    logic [DATA_W-1:0]   word;

    mbist_seq i_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .sel      (pattern_sel),
        .at_end   (at_end),
        .launch   (launch),
        .accept   (accept),
        .issue    (issue),
        .op       (op),
        .load     (load),
        .load_down(load_down),
        .step     (step),
        .dir_down (dir_down),
        .alg      (alg),
        .col_fast (col_fast),
        .busy     (busy),
        .done     (done)
    );

    mbist_addr #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) i_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_down(load_down),
        .step     (step),
        .dir_down (dir_down),
        .col_fast (col_fast),
        .row      (row),
        .col      (col),
        .at_end   (at_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            seed_q <= '0;
        end else if (accept) begin
            seed_q <= seed;
        end
    end

    always_comb begin
        word      = {REP{seed_q}} ^ {DATA_W{bg_flip(alg, row[0], col[0]) ^ op.inv}};
        mem_addr  = {row, col};
        mem_we    = issue && op.wr;
        mem_re    = issue && op.rd;
        mem_wdata = word;
    end

    mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cmp (
        .clk          (clk),
        .rst          (rst),
        .clear        (launch),
        .rd_issue     (mem_re),
        .rd_addr      (mem_addr),
        .rd_expect    (word),
        .rdata        (mem_rdata),
        .fail         (fail),
        .fail_addr    (fail_addr),
        .fail_expected(fail_expected)
    );
endmodule

// File: rtl/mbist_engine_chk.sv
module mbist_engine_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [DATA_W-1:0] fail_expected
);
    a_r9_single_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !mem_re));

    a_r11_done_excludes_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r11_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    a_r10_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);

    a_r10_capture_kept: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> ($stable(fail_addr) && $stable(fail_expected)));
endmodule

bind mbist_engine mbist_engine_chk #(.ADDR_W(ROW_BITS + COL_BITS), .DATA_W(DATA_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .fail         (fail),
    .mem_we       (mem_we),
    .mem_re       (mem_re),
    .fail_addr    (fail_addr),
    .fail_expected(fail_expected)
);

// File: tb/test_mbist_engine.sv
`timescale 1ns/1ps
module test_mbist_engine;
    localparam int RB = 2, CB = 2, DW = 8;
    localparam int ROWS = 1 << RB, COLS = 1 << CB, NW = ROWS * COLS;

    logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [5:0]    pattern_sel = '0;
    logic [3:0]    seed = '0;
    logic [RB+CB-1:0] mem_addr, fail_addr;
    logic          mem_we, mem_re, busy, done, fail;
    logic [DW-1:0] mem_wdata, mem_rdata, fail_expected;

    int errors = 0, checks = 0;
    logic [DW-1:0] model [NW];
    logic          flt_on = 1'b0;
    int            flt_addr = 0, flt_bit = 0;

    always #4 clk = ~clk;

    mbist_engine #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW)) i_mbist_engine (
        .clk(clk), .rst(rst), .start(start), .pattern_sel(pattern_sel), .seed(seed),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_expected(fail_expected)
    );

    // SRAM model with an optional stuck-at-1 bit
    always @(posedge clk) begin
        if (mem_we) begin
            if (flt_on && int'(mem_addr) == flt_addr)
                model[mem_addr] <= mem_wdata | DW'(1 << flt_bit);
            else
                model[mem_addr] <= mem_wdata;
        end
        if (mem_re) mem_rdata <= model[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference elements: uppercase = true data, lowercase = inverse.
    function automatic string ref_elem(input int alg, input int e);
        if (alg < 4) begin
            case (e) 0: return "W"; 1: return "R"; 2: return "w"; default: return "r"; endcase
        end else if (alg == 4) begin
            case (e) 0: return "W"; 1: return "Rw"; 2: return "rW"; default: return "R"; endcase
        end else if (alg == 5) begin
            case (e) 0: return "W"; 1: return "Rwr"; 2: return "rWR"; default: return "R"; endcase
        end
        case (e) 0: return "W"; 1: return "Rwr"; 2: return "rWR"; 3: return "Rwr"; 4: return "rWR"; default: return "R"; endcase
    endfunction

    function automatic int ref_nelem(input int alg);
        return (alg == 6) ? 6 : 4;
    endfunction

    function automatic bit ref_down(input int alg, input int e);
        if (alg == 4 || alg == 5) return e == 2;
        if (alg == 6) return e >= 3;
        return 1'b0;
    endfunction

    function automatic bit ref_bg(input int alg, input int r, input int c);
        case (alg)
            0: return ((r ^ c) & 1) == 1;
            1: return (c & 1) == 1;
            2: return (r & 1) == 1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run(input logic [5:0] sel, input logic [3:0] sd,
                       input bit fon, input int fa, input int fb);
        int alg = int'(sel[2:0]);
        bit cf = sel[3];
        bit rf = 1'b0;
        int rf_addr = 0;
        logic [DW-1:0] rf_exp = '0;
        string tag = (alg < 4) ? "R5 R3 R4 R9" : (alg == 4) ? "R6 R3 R9" : (alg == 5) ? "R7 R3 R9" : "R8 R3 R9";
        flt_on = fon; flt_addr = fa; flt_bit = fb;
        start = 1'b1; pattern_sel = sel; seed = sd;
        @(negedge clk);
        start = 1'b0;
        for (int e = 0; e < ref_nelem(alg); e++) begin
            string s = ref_elem(alg, e);
            bit dn = ref_down(alg, e);
            for (int k = 0; k < NW; k++) begin
                int p = dn ? NW - 1 - k : k;
                int r = cf ? p % ROWS : p / COLS;
                int c = cf ? p / ROWS : p % COLS;
                int a = r * COLS + c;
                for (int o = 0; o < s.len(); o++) begin
                    byte ch = s[o];
                    bit wr = (ch == "W") || (ch == "w");
                    bit iv = (ch == "w") || (ch == "r");
                    logic [DW-1:0] ex = {(DW/4){sd}} ^ {DW{ref_bg(alg, r, c) ^ iv}};
                    logic [31:0] act = {15'd0, mem_addr, mem_we, mem_re, busy, (mem_we ? mem_wdata : 8'h00)};
                    logic [31:0] exv = {15'd0, 4'(a), wr, !wr, 1'b1, (wr ? ex : 8'h00)};
                    chk(act == exv, tag, act, exv);
                    if (!wr && !rf && model[a] != ex) begin
                        rf = 1'b1; rf_addr = a; rf_exp = ex;
                    end
                    @(negedge clk);
                end
            end
        end
        @(negedge clk);
        chk(done && !busy, "R11 done two cycles after last access", {30'd0, done, busy}, 32'h2);
        chk(fail == rf, "R10 fail flag", 32'(fail), 32'(rf));
        if (rf) begin
            chk(int'(fail_addr) == rf_addr, "R10 first fail address", 32'(fail_addr), 32'(rf_addr));
            chk(fail_expected == rf_exp, "R10 first fail expected", 32'(fail_expected), 32'(rf_exp));
        end
        flt_on = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        chk({busy, done, fail, mem_we, mem_re} == 5'b0, "R1 reset state",
            {27'd0, busy, done, fail, mem_we, mem_re}, 32'd0);
        repeat (2) @(negedge clk);
        chk(!busy && !mem_we && !mem_re, "R1 no access without start", {30'd0, mem_we, mem_re}, 32'd0);

        // R2: sweep of every algorithm, both axes, two seeds
        for (int a = 0; a < 7; a++)
            for (int cf = 0; cf < 2; cf++)
                for (int s = 0; s < 2; s++)
                    run({2'b00, 1'(cf), 3'(a)}, s ? 4'hC : 4'h5, 1'b0, 0, 0);

        // R10: injected stuck-at faults
        run(6'h00, 4'h5, 1'b1, 6, 2);
        run(6'h0E, 4'hA, 1'b1, 9, 7);
        run(6'h05, 4'h3, 1'b1, 15, 0);
        run(6'h09, 4'h0, 1'b1, 0, 1);
        run(6'h03, 4'hF, 1'b1, 4, 5);

        // R11: done held, fail held across idle cycles
        repeat (4) @(negedge clk);
        chk(done && fail, "R11 done and R10 fail held", {30'd0, done, fail}, 32'h3);

        // R2: unsupported codes make no access and clear fail
        start = 1'b1; pattern_sel = 6'h17;
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy && !fail && !mem_we && !mem_re, "R2 bad upper bits",
            {27'd0, done, busy, fail, mem_we, mem_re}, 32'h10);
        start = 1'b1; pattern_sel = 6'h0F;
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy && !mem_we && !mem_re, "R2 algorithm 7",
            {28'd0, done, busy, mem_we, mem_re}, 32'h8);
        repeat (2) @(negedge clk);
        chk(!mem_we && !mem_re, "R2 still no access", {30'd0, mem_we, mem_re}, 32'd0);

        // R11: a clean run after a failing one ends with fail cleared
        run(6'h00, 4'h5, 1'b1, 3, 0);
        run(6'h06, 4'h9, 1'b0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule